// File: doc/BRIEF.md
# Dual Timer/Counter with Overflow Toggle

The block holds two independent 16-bit timer/counters behind a small byte-wide register bus. Each unit counts in one of two ways. In timer mode it counts cycles in which the peripheral tick enable is high. In counter mode it counts falling edges of its own external input, which first passes through a synchronizer. Each unit has a run bit, and a gate option that also needs its gate pin to be high before it counts. When a unit overflows it sets a sticky overflow flag. If its toggle bit is enabled, it also inverts its own output pin.

Each unit's mode is a three-bit code. Two bits sit in a nibble of the shared mode register, and the third bit sits in a separate auxiliary register. Code 001 selects a free-running 16-bit count. Code 010 selects an 8-bit count in the low byte, which reloads from the high byte on overflow. All other codes freeze the unit. Reads are combinational from the address; writes take effect at the clock edge when the write enable is high.

Top module: `tmr_dual`

## Requirements
- R1: After reset, every register reads 0x00 and both toggle outputs are 0.
- R2: The register map is as follows. Address 0 and address 2 are the low and high count bytes of unit 0. Address 1 and address 3 are the low and high count bytes of unit 1. Address 4 is the mode register. Address 5 is the control register. Address 6 is the auxiliary mode register. Address 7 is the toggle enable register. In the mode register, unit 1 uses bits 7:4 and unit 0 uses bits 3:0. Within each nibble, from the top bit down, the fields are gate, counter select, mode bit 1 and mode bit 0. The mode register reads back exactly what was written.
- R3: The control register holds, from bit 7 down to bit 4, the unit 1 flag, the unit 1 run bit, the unit 0 flag and the unit 0 run bit. Its bits 3:0 read 0. The auxiliary register keeps only bit 4 (mode bit 2 of unit 1) and bit 0 (mode bit 2 of unit 0). The toggle enable register keeps only bit 0 (unit 0) and bit 1 (unit 1). In all three registers, writes to the other bits are ignored and those bits read 0.
- R4: A unit advances only while its run bit is 1 and, when its gate bit is 1, its gate pin is also high.
- R5: With counter select 0, a running unit advances by one for each clock in which tick_en is high.
- R6: With counter select 1, a running unit advances by one for each falling edge of its external input, after synchronization, and ignores tick_en.
- R7: Mode 001 counts 16 bits and wraps from 0xFFFF to 0x0000, setting the unit's flag.
- R8: Mode 010 counts the low byte. On overflow from 0xFF the low byte loads the high byte's value, the high byte stays unchanged, and the flag is set.
- R9: Mode codes other than 001 and 010 hold the count unchanged.
- R10: A flag stays at 1 until software writes 0 to it. If an overflow happens in the same cycle as a write that clears the flag, the overflow wins.
- R11: When its toggle enable is 1, a unit's output inverts at the same edge that sets its flag. At no other time does the output change.
- R12: A write to either count byte of a unit cancels that unit's increment in that cycle. The written byte takes the bus value and the other byte holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Peripheral tick enable for timer mode |
| ext_cnt | input | 2 | External count inputs, bit i for unit i |
| gate_pin | input | 2 | Gate pins, bit i for unit i |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr |
| tog_out | output | 2 | Overflow toggle outputs, bit i for unit i |

## Verification
The assertions check several rules on every cycle:
- a stopped or gated unit never moves its count;
- a 16-bit overflow leaves zero;
- an 8-bit overflow copies the high byte;
- frozen mode codes keep the count;
- a flag only rises through overflow or a software write, and stays set until it is cleared;
- a toggle output changes exactly when an enabled overflow occurs;
- the edge detector never pulses twice in a row.

The bench scenarios show the rest:
- that the number of counted external edges matches the number of pulses;
- that tick_en has no effect in counter mode;
- the register field positions and the bits that are ignored;
- that a count write cancels an increment;
- that long random runs of ticks and gate patterns land on the counts, flags and outputs that an independent model predicts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = 2 * BYTE_W;
   localparam int ADDR_W = 3;
   localparam int MODE_W = 3;

   localparam logic [ADDR_W-1:0] A_LO0  = 3'd0;
   localparam logic [ADDR_W-1:0] A_LO1  = 3'd1;
   localparam logic [ADDR_W-1:0] A_HI0  = 3'd2;
   localparam logic [ADDR_W-1:0] A_HI1  = 3'd3;
   localparam logic [ADDR_W-1:0] A_MODE = 3'd4;
   localparam logic [ADDR_W-1:0] A_CTRL = 3'd5;
   localparam logic [ADDR_W-1:0] A_AUX  = 3'd6;
   localparam logic [ADDR_W-1:0] A_TOG  = 3'd7;

   localparam logic [MODE_W-1:0] MODE_WIDE16 = 3'b001;
   localparam logic [MODE_W-1:0] MODE_RLD8   = 3'b010;

   typedef struct packed {
      logic       gate;
      logic       ext_sel;
      logic [1:0] m;
   } mode_nib_t;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmr_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-1:0], din};
   end

   assign fall = sh[STAGES] & ~sh[STAGES-1];

   // R6: one edge gives one pulse
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
   import tmr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic [MODE_W-1:0] mode,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] lo,
   output logic [BYTE_W-1:0] hi,
   output logic              ovf
);
   logic              step;
   logic [BYTE_W-1:0] nxt_lo, nxt_hi;
   logic [CNT_W-1:0]  sum;

   assign step = inc & ~wr_lo & ~wr_hi;
   assign sum  = {hi, lo} + CNT_W'(1);

   always_comb begin
      nxt_lo = lo;
      nxt_hi = hi;
      ovf    = 1'b0;
      if (step) begin
         case (mode)
            MODE_WIDE16: begin
               {nxt_hi, nxt_lo} = sum;
               ovf = &{hi, lo};
            end
            MODE_RLD8: begin
               ovf    = &lo;
               nxt_lo = (&lo) ? hi : lo + BYTE_W'(1);
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo <= '0;
         hi <= '0;
      end else begin
         lo <= wr_lo ? wr_data : nxt_lo;
         hi <= wr_hi ? wr_data : nxt_hi;
      end
   end

   // R7: a 16-bit wrap leaves zero
   a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_WIDE16 && ovf) |=> (lo == '0 && hi == '0));
   // R8: an 8-bit overflow copies the high byte
   a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_RLD8 && ovf) |=> (lo == $past(hi) && $stable(hi)));
   // R9: frozen codes hold the count
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MODE_WIDE16 && mode != MODE_RLD8 && !wr_lo && !wr_hi)
      |=> ($stable(lo) && $stable(hi)));
endmodule

// File: rtl/tmr_dual.sv
module tmr_dual
   import tmr_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [1:0]        ext_cnt,
   input  logic [1:0]        gate_pin,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] rd_data,
   output logic [1:0]        tog_out
);
   localparam int N_UNIT = 2;
   localparam int NIB_W  = BYTE_W / 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tmr_dual: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [BYTE_W-1:0] mode_q;
   logic [N_UNIT-1:0] m2_q, tr_q, tf_q, tog_en_q, tog_q;
   logic [N_UNIT-1:0] fall, inc, ovf, wr_lo, wr_hi;
   logic [BYTE_W-1:0] cnt_lo [N_UNIT];
   logic [BYTE_W-1:0] cnt_hi [N_UNIT];
   logic              ctrl_wr;

   assign ctrl_wr = wr_en && (addr == A_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= '0;
         m2_q     <= '0;
         tog_en_q <= '0;
      end else if (wr_en) begin
         if (addr == A_MODE) mode_q <= wr_data;
         if (addr == A_AUX)  m2_q <= {wr_data[4], wr_data[0]};
         if (addr == A_TOG)  tog_en_q <= wr_data[1:0];
      end
   end

   genvar i;
   generate
      for (i = 0; i < N_UNIT; i++) begin : g_unit
         mode_nib_t         nib;
         logic [MODE_W-1:0] mcode;
         logic              src;

         assign nib   = mode_nib_t'(mode_q[NIB_W*i +: NIB_W]);
         assign mcode = {m2_q[i], nib.m};

         tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (ext_cnt[i]),
            .fall (fall[i])
         );

         assign src    = nib.ext_sel ? fall[i] : tick_en;
         assign inc[i] = tr_q[i] & (~nib.gate | gate_pin[i]) & src;
         assign wr_lo[i] = wr_en && (addr == (i == 0 ? A_LO0 : A_LO1));
         assign wr_hi[i] = wr_en && (addr == (i == 0 ? A_HI0 : A_HI1));

         tmr_counter u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (inc[i]),
            .mode   (mcode),
            .wr_lo  (wr_lo[i]),
            .wr_hi  (wr_hi[i]),
            .wr_data(wr_data),
            .lo     (cnt_lo[i]),
            .hi     (cnt_hi[i]),
            .ovf    (ovf[i])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tf_q[i]  <= 1'b0;
               tr_q[i]  <= 1'b0;
               tog_q[i] <= 1'b0;
            end else begin
               if (ovf[i])       tf_q[i] <= 1'b1;
               else if (ctrl_wr) tf_q[i] <= wr_data[NIB_W + 2*i + 1];
               if (ctrl_wr)      tr_q[i] <= wr_data[NIB_W + 2*i];
               if (ovf[i] && tog_en_q[i]) tog_q[i] <= ~tog_q[i];
            end
         end

         // R4: stopped or gated units keep their count
         a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ((!tr_q[i] || (nib.gate && !gate_pin[i])) && !wr_lo[i] && !wr_hi[i])
            |=> ($stable(cnt_lo[i]) && $stable(cnt_hi[i])));
         // R10: the flag is sticky until a control write
         a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (tf_q[i] && !ctrl_wr) |=> tf_q[i]);
         // R10: overflow wins over a clearing write
         a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[i] |=> tf_q[i]);
         // R10: a flag rises only through overflow or software
         a_r10_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(tf_q[i]) && !$past(ctrl_wr)) |-> $past(ovf[i]));
         // R11: an enabled overflow inverts the output
         a_r11_toggle: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf[i] && tog_en_q[i]) |=> (tog_q[i] != $past(tog_q[i])));
         // R11: otherwise the output is quiet
         a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !(ovf[i] && tog_en_q[i]) |=> $stable(tog_q[i]));
      end
   endgenerate

   assign tog_out = tog_q;

   always_comb begin
      case (addr)
         A_LO0:   rd_data = cnt_lo[0];
         A_LO1:   rd_data = cnt_lo[1];
         A_HI0:   rd_data = cnt_hi[0];
         A_HI1:   rd_data = cnt_hi[1];
         A_MODE:  rd_data = mode_q;
         A_CTRL:  rd_data = {tf_q[1], tr_q[1], tf_q[0], tr_q[0], 4'b0000};
         A_AUX:   rd_data = {3'b000, m2_q[1], 3'b000, m2_q[0]};
         default: rd_data = {6'b000000, tog_en_q};
      endcase
   end
endmodule

// File: tb/tmr_dual_bench.sv
module tmr_dual_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [1:0] ext_cnt = 2'b11;
   logic [1:0] gate_pin = 2'b00;
   logic       wr_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic [1:0] tog_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model state for the random phase
   logic [2:0]  m_mode [2];
   logic        m_gate [2];
   logic        m_ten  [2];
   logic [15:0] m_cnt  [2];
   logic        m_tf   [2];
   logic        m_tog  [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_dual u_tmr_dual (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_cnt(ext_cnt),
      .gate_pin(gate_pin), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .tog_out(tog_out)
   );

   function automatic logic [16:0] adv(input logic [2:0] md, input logic [15:0] c);
      if (md == 3'b001)      return {c == 16'hFFFF, c + 16'd1};
      else if (md == 3'b010) return (c[7:0] == 8'hFF) ? {1'b1, c[15:8], c[15:8]}
                                                      : {1'b0, c[15:8], c[7:0] + 8'd1};
      else                   return {1'b0, c};
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rd_data;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(posedge clk);
      #1 tick_en = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'd20241));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         chk("R1 reset read", {8'h0, d}, 16'h0);
      end
      chk("R1 toggle outputs", {14'h0, tog_out}, 16'h0);

      // R2 / R3: field layout and ignored bits
      wr(3'd4, 8'hA5); rd(3'd4, d); chk("R2 mode readback", {8'h0, d}, 16'h00A5);
      wr(3'd6, 8'hFF); rd(3'd6, d); chk("R3 aux keeps bits 4 and 0", {8'h0, d}, 16'h0011);
      wr(3'd5, 8'h0F); rd(3'd5, d); chk("R3 ctrl low nibble ignored", {8'h0, d}, 16'h0000);
      wr(3'd7, 8'hFC); rd(3'd7, d); chk("R3 toggle reg ignores upper bits", {8'h0, d}, 16'h0000);
      wr(3'd6, 8'h00); wr(3'd4, 8'h00);

      // R5: timer mode, unit 0 in 16-bit mode
      wr(3'd4, 8'h01); wr(3'd0, 8'h00); wr(3'd2, 8'h00); wr(3'd5, 8'h10);
      ticks(10);
      rd(3'd0, d); chk("R5 counts ticks", {8'h0, d}, 16'd10);
      // R4: gate low blocks, gate high passes, run off blocks
      wr(3'd4, 8'h09); gate_pin = 2'b00;
      ticks(5); rd(3'd0, d); chk("R4 gated low holds", {8'h0, d}, 16'd10);
      gate_pin = 2'b01;
      ticks(3); rd(3'd0, d); chk("R4 gate high counts", {8'h0, d}, 16'd13);
      wr(3'd5, 8'h00);
      ticks(4); rd(3'd0, d); chk("R4 run off holds", {8'h0, d}, 16'd13);
      gate_pin = 2'b00;

      // R6: unit 1 counts external falling edges, ignores tick_en
      wr(3'd4, 8'h50); wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd5, 8'h40);
      @(negedge clk); tick_en = 1'b1;
      for (int p = 0; p < 5; p++) begin
         @(negedge clk); ext_cnt[1] = 1'b0;
         repeat (4) @(negedge clk);
         ext_cnt[1] = 1'b1;
         repeat (4) @(negedge clk);
      end
      tick_en = 1'b0;
      repeat (5) @(negedge clk);
      rd(3'd1, d); chk("R6 edge count", {8'h0, d}, 16'd5);
      wr(3'd5, 8'h00);

      // R7 / R11 / R10: 16-bit wrap with toggle
      wr(3'd4, 8'h01); wr(3'd7, 8'h01); wr(3'd0, 8'hFE); wr(3'd2, 8'hFF); wr(3'd5, 8'h10);
      ticks(1);
      rd(3'd5, d); chk("R7 no flag before wrap", {15'h0, d[5]}, 16'd0);
      ticks(1);
      rd(3'd0, d); chk("R7 low byte wrapped", {8'h0, d}, 16'h00);
      rd(3'd2, d); chk("R7 high byte wrapped", {8'h0, d}, 16'h00);
      rd(3'd5, d); chk("R7 flag set", {15'h0, d[5]}, 16'd1);
      chk("R11 output toggled", {15'h0, tog_out[0]}, 16'd1);
      ticks(6);
      chk("R11 output steady", {15'h0, tog_out[0]}, 16'd1);
      rd(3'd5, d); chk("R10 flag sticky", {15'h0, d[5]}, 16'd1);
      wr(3'd5, 8'h10); rd(3'd5, d); chk("R10 software clear", {8'h0, d}, 16'h0010);

      // R8: 8-bit reload
      wr(3'd4, 8'h02); wr(3'd2, 8'h80); wr(3'd0, 8'hFE);
      ticks(2);
      rd(3'd0, d); chk("R8 low reloaded", {8'h0, d}, 16'h80);
      rd(3'd2, d); chk("R8 high unchanged", {8'h0, d}, 16'h80);
      rd(3'd5, d); chk("R8 flag set", {15'h0, d[5]}, 16'd1);
      ticks(3); rd(3'd0, d); chk("R8 counts after reload", {8'h0, d}, 16'h83);

      // R9: frozen codes 000 and 101
      wr(3'd4, 8'h00); ticks(4); rd(3'd0, d); chk("R9 code 000 holds", {8'h0, d}, 16'h83);
      wr(3'd4, 8'h01); wr(3'd6, 8'h01); ticks(4); rd(3'd0, d);
      chk("R9 code 101 holds", {8'h0, d}, 16'h83);
      wr(3'd6, 8'h00);

      // R12: write beats increment
      @(negedge clk); tick_en = 1'b1;
      wr(3'd0, 8'h40);
      tick_en = 1'b0;
      rd(3'd0, d); chk("R12 written value kept", {8'h0, d}, 16'h40);
      rd(3'd2, d); chk("R12 other byte holds", {8'h0, d}, 16'h80);
      wr(3'd5, 8'h00);
      m_tog[0] = tog_out[0]; m_tog[1] = tog_out[1];

      // random phase, timer mode only; R7 R8 R9 R4 R11 against model
      for (int seg = 0; seg < 6; seg++) begin
         logic [7:0] mreg, aux, ten;
         mreg = 8'h00; aux = 8'h00; ten = 8'h00;
         for (int u = 0; u < 2; u++) begin
            case ($urandom % 4)
               0: m_mode[u] = 3'b010;
               1: m_mode[u] = 3'b000;
               default: m_mode[u] = 3'b001;
            endcase
            m_gate[u] = 1'($urandom % 2);
            m_ten[u]  = 1'($urandom % 2);
            m_cnt[u][15:8] = ($urandom % 2) ? 8'hFF : 8'($urandom);
            m_cnt[u][7:0]  = 8'hE0 | 8'($urandom % 32);
            m_tf[u] = 1'b0;
            mreg[4*u +: 4] = {m_gate[u], 1'b0, m_mode[u][1:0]};
            aux[4*u] = m_mode[u][2];
            ten[u] = m_ten[u];
         end
         wr(3'd4, mreg); wr(3'd6, aux); wr(3'd7, ten);
         wr(3'd0, m_cnt[0][7:0]); wr(3'd2, m_cnt[0][15:8]);
         wr(3'd1, m_cnt[1][7:0]); wr(3'd3, m_cnt[1][15:8]);
         wr(3'd5, 8'h50);
         for (int s = 0; s < 200; s++) begin
            logic tk;
            logic [1:0] gp;
            logic [16:0] r;
            tk = ($urandom % 4) != 0;
            gp = 2'($urandom);
            @(negedge clk);
            tick_en = tk; gate_pin = gp;
            for (int u = 0; u < 2; u++) begin
               if (tk && (!m_gate[u] || gp[u])) begin
                  r = adv(m_mode[u], m_cnt[u]);
                  m_cnt[u] = r[15:0];
                  if (r[16]) begin
                     m_tf[u] = 1'b1;
                     if (m_ten[u]) m_tog[u] = ~m_tog[u];
                  end
               end
            end
         end
         @(negedge clk); tick_en = 1'b0;
         for (int u = 0; u < 2; u++) begin
            logic [7:0] lo, hi, ct;
            rd(3'(u), lo); rd(3'(u + 2), hi); rd(3'd5, ct);
            chk("R7/R8/R9 random count", {hi, lo}, m_cnt[u]);
            chk("R10 random flag", {15'h0, ct[5 + 2*u]}, {15'h0, m_tf[u]});
            chk("R11 random toggle", {15'h0, tog_out[u]}, {15'h0, m_tog[u]});
            chk("R4 random run bit", {15'h0, ct[4 + 2*u]}, 16'd1);
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule